// File: doc/BRIEF.md
# Masked Component Register File

This block holds the configuration and capability words of a cache/memory interconnect component. It sits behind a plain 32-bit register bus made of address, write data, write enable, read enable, an access-size flag and read data. Each implemented word has a per-bit write mask. A write keeps the old value in every bit whose mask bit is zero, so read-only fields survive software writes. The header contents, the set of advertised capabilities and the mask set all depend on a component-type code. This code is captured while reset is held.

The block contains one memory-range decoder register group with a commit handshake. Software writes the decoder control word with its commit request bit set. In that same update the request bit is cleared, the error flag is cleared and a committed flag is raised. Reads are combinational from the stored words, and a write takes effect at the clock edge on which it is presented. Reset is synchronous and active low. Every word is rebuilt from the type code on each edge while reset is low.

Top module: `cmreg_file`

## Requirements
- R1: Only accesses with `bus_size`=0 (4 bytes) are serviced. With `bus_size`=1 a read returns 0 and a write changes no stored word.
- R2: A serviced write at a word-aligned, implemented address stores (wdata & mask) | (old & ~mask). Words whose mask is zero keep their reset value.
- R3: The decoder control word is at byte 0xA0, with commit request at bit 9, committed at bit 10 and error at bit 11. When a write leaves bit 9 set after merging, the stored word has bit 9 = 0, bit 11 = 0 and bit 10 = 1 in the same update. Bit 10 is then read-only and stays set until reset.
- R4: The decoder control word has write mask 0x13FF. The global decoder control word at 0x84 has mask 0x3 and resets to 0.
- R5: The decoder base-low (0x90) and size-low (0x98) words have mask 0xF0000000. Base-high (0x94), size-high (0x9C) and target-high (0xA8) are fully writable. The decoder group repeats every 0x20 bytes.
- R6: The target-low word (0xA4) has mask 0xF0000000 for endpoint types (1 plain device, 3 type-3 device, 4 logical device) and 0xFFFFFFFF for port types (0 downstream, 2 upstream, 5 root).
- R7: The header word at 0x00 reads {array size[31:24], 8'h01, 8'h01, 8'h01}. The array size is 3 for types 2, 3 and 4, it is 5 for type 5, and it is 2 for types 0, 1, 6 and 7. The header word is read-only.
- R8: The capability entries at 0x04..0x14 are laid out as {pointer[31:20], version[19:16], id[15:0]}, in this order: error-reporting (id 2, v2, 0x040), link (id 4, v2, 0x060), decoder (id 5, v1, 0x080), extended security (id 6, v1, 0x100), snoop (id 8, v1, 0x140). Entries beyond the array size read 0.
- R9: The error words are the uncorrectable status (0x40), uncorrectable mask (0x44), uncorrectable severity (0x48), correctable status (0x4C) and correctable mask (0x50). The uncorrectable mask and severity reset to 0x1CFFF with mask 0x1CFFF. The correctable mask resets to 0x7F with mask 0x7F. Both status words read 0 and cannot be written.
- R10: When the decoder capability is advertised, the word at 0x80 reads 0x310: decoder-count code 0 for one decoder in bits 3:0, target count 1 in bits 7:4, 256-byte interleave at bit 8, 4-KiB interleave at bit 9, and no poison at bit 10. Otherwise the whole decoder block (0x80..0xAC) reads 0 and ignores writes.
- R11: A read or write at a non-aligned address, or at an address at or above 0xB0, returns 0 or is ignored. `bus_rdata` is 0 whenever `bus_re` is low.
- R12: Reset rebuilds every word. The type used is the value of `comp_type` on the last edge with reset low. Changes to `comp_type` after reset, and writes presented during reset, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comp_type | input | 3 | Component-type code captured during reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_size | input | 1 | 0 = 4-byte access, 1 = 8-byte access |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
Two functions can act in the same write: the mask merge and the commit self-clear. A single write to the control word can change the writable bits and also trigger the commit rewrite of read-only bits.

The bench provokes this case in two ways. Directed writes pair the commit bit with various low-field patterns. Random writes often hit 0xA0 with arbitrary data, including set read-only bits 10 and 11. Each result is judged against a bench model that applies the merge first and then the commit rewrite.

Reset and a write can also coincide. The bench holds a write on the bus while reset is low and confirms that the rebuilt values win.

// File: rtl/cmreg_pkg.sv
package cmreg_pkg;

    typedef enum logic [2:0] {
        CT_DSP  = 3'd0,
        CT_DEV  = 3'd1,
        CT_USP  = 3'd2,
        CT_T3   = 3'd3,
        CT_LD   = 3'd4,
        CT_RP   = 3'd5,
        CT_RSV6 = 3'd6,
        CT_RSV7 = 3'd7
    } comp_t;

    // word indices of the map
    localparam int unsigned HDR_W        = 0;
    localparam int unsigned CAPE_W0      = 1;
    localparam int unsigned CAPE_NUM     = 5;
    localparam int unsigned UNC_ST_W     = 16;
    localparam int unsigned UNC_MSK_W    = 17;
    localparam int unsigned UNC_SEV_W    = 18;
    localparam int unsigned COR_ST_W     = 19;
    localparam int unsigned COR_MSK_W    = 20;
    localparam int unsigned HDM_CAP_W    = 32;
    localparam int unsigned HDM_GCTL_W   = 33;
    localparam int unsigned DEC_W0       = 36;
    localparam int unsigned DEC_STRIDE_W = 8;
    localparam int unsigned CTL_OFS      = 4;

    // decoder control bit positions
    localparam int unsigned CTL_COMMIT    = 9;
    localparam int unsigned CTL_COMMITTED = 10;
    localparam int unsigned CTL_ERR       = 11;

    localparam logic [31:0] UNC_BITS  = 32'h0001_CFFF;
    localparam logic [31:0] COR_BITS  = 32'h0000_007F;
    localparam logic [31:0] LOW_ONLY  = 32'hF000_0000;
    localparam logic [31:0] ALL_BITS  = 32'hFFFF_FFFF;
    localparam logic [31:0] CTL_BITS  = 32'h0000_13FF;
    localparam logic [31:0] GCTL_BITS = 32'h0000_0003;
    localparam logic [31:0] HDM_FEAT  = 32'h0000_0310;

    function automatic int unsigned cap_count(comp_t t);
        case (t)
            CT_USP, CT_T3, CT_LD: return 3;
            CT_RP:                return 5;
            default:              return 2;
        endcase
    endfunction

    function automatic logic is_endpoint(comp_t t);
        return (t == CT_DEV) || (t == CT_T3) || (t == CT_LD);
    endfunction

    function automatic logic [3:0] dec_count_code(int unsigned n);
        return (n <= 1) ? 4'd0 : 4'(n / 2);
    endfunction

    function automatic logic [31:0] cap_entry(int unsigned k);
        case (k)
            0:       return {12'h040, 4'd2, 16'd2};
            1:       return {12'h060, 4'd2, 16'd4};
            2:       return {12'h080, 4'd1, 16'd5};
            3:       return {12'h100, 4'd1, 16'd6};
            4:       return {12'h140, 4'd1, 16'd8};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] reset_word(comp_t t, int unsigned w, int unsigned ndec);
        int unsigned caps;
        logic [31:0] r;
        caps = cap_count(t);
        r    = 32'h0;
        if (w == HDR_W)
            r = {8'(caps), 8'h01, 8'h01, 8'h01};
        else if (w >= CAPE_W0 && w < CAPE_W0 + CAPE_NUM && (w - CAPE_W0) < caps)
            r = cap_entry(w - CAPE_W0);
        else if (w == UNC_MSK_W || w == UNC_SEV_W)
            r = UNC_BITS;
        else if (w == COR_MSK_W)
            r = COR_BITS;
        else if (w == HDM_CAP_W && caps >= 3)
            r = HDM_FEAT | {28'h0, dec_count_code(ndec)};
        return r;
    endfunction

    function automatic logic [31:0] mask_word(comp_t t, int unsigned w, int unsigned ndec);
        logic [31:0] m;
        m = 32'h0;
        if (w == UNC_MSK_W || w == UNC_SEV_W)
            m = UNC_BITS;
        else if (w == COR_MSK_W)
            m = COR_BITS;
        else if (cap_count(t) >= 3) begin
            if (w == HDM_GCTL_W)
                m = GCTL_BITS;
            else if (w >= DEC_W0 && w < DEC_W0 + DEC_STRIDE_W * ndec) begin
                case ((w - DEC_W0) % DEC_STRIDE_W)
                    0, 2:    m = LOW_ONLY;
                    1, 3, 6: m = ALL_BITS;
                    4:       m = CTL_BITS;
                    5:       m = is_endpoint(t) ? LOW_ONLY : ALL_BITS;
                    default: m = 32'h0;
                endcase
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/cmreg_addr_dec.sv
module cmreg_addr_dec #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 44,
    parameter int unsigned IDX_W     = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size_wide,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned WA_W = ADDR_W - 2;

    logic [WA_W-1:0] word_addr;

    assign word_addr = addr[ADDR_W-1:2];
    assign idx       = IDX_W'(word_addr);
    assign hit       = !size_wide && (addr[1:0] == 2'b00) && (word_addr < WA_W'(NUM_WORDS));
endmodule

// File: rtl/cmreg_table.sv
module cmreg_table
    import cmreg_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 44,
    parameter int unsigned NUM_DEC   = 1,
    parameter bit          MASK_SEL  = 1'b0
) (
    input  comp_t                        kind,
    output logic [NUM_WORDS-1:0][31:0]   tbl
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        if (MASK_SEL) begin : g_mask
            assign tbl[w] = mask_word(kind, w, NUM_DEC);
        end else begin : g_rst
            assign tbl[w] = reset_word(kind, w, NUM_DEC);
        end
    end
endmodule

// File: rtl/cmreg_merge.sv
module cmreg_merge
    import cmreg_pkg::*;
(
    input  logic [31:0] old_word,
    input  logic [31:0] wdata,
    input  logic [31:0] mask,
    input  logic        is_ctrl,
    output logic [31:0] new_word
);
    logic [31:0] blended;

    always_comb begin
        blended  = (wdata & mask) | (old_word & ~mask);
        new_word = blended;
        if (is_ctrl && blended[CTL_COMMIT]) begin
            new_word[CTL_COMMIT]    = 1'b0;
            new_word[CTL_ERR]       = 1'b0;
            new_word[CTL_COMMITTED] = 1'b1;
        end
    end
endmodule

// File: rtl/cmreg_file.sv
module cmreg_file
    import cmreg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned NUM_DEC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        comp_type,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic              bus_size,
    output logic [31:0]       bus_rdata
);
    localparam int unsigned NUM_WORDS = DEC_W0 + DEC_STRIDE_W * NUM_DEC;
    localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

    typedef struct packed {
        comp_t                      kind;
        logic [NUM_WORDS-1:0][31:0] words;
    } state_t;

    state_t st_d, st_q;

    logic                       hit;
    logic [IDX_W-1:0]           idx;
    logic                       is_ctrl;
    logic [31:0]                merged;
    logic [NUM_WORDS-1:0][31:0] rst_tbl;
    logic [NUM_WORDS-1:0][31:0] msk_tbl;
    comp_t                      kind_in;

    assign kind_in = comp_t'(comp_type);

    cmreg_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W)
    ) u_dec (
        .addr      (bus_addr),
        .size_wide (bus_size),
        .hit       (hit),
        .idx       (idx)
    );

    cmreg_table #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_DEC   (NUM_DEC),
        .MASK_SEL  (1'b0)
    ) u_rst_tbl (
        .kind (kind_in),
        .tbl  (rst_tbl)
    );

    cmreg_table #(
        .NUM_WORDS (NUM_WORDS),
        .NUM_DEC   (NUM_DEC),
        .MASK_SEL  (1'b1)
    ) u_msk_tbl (
        .kind (st_q.kind),
        .tbl  (msk_tbl)
    );

    always_comb begin
        is_ctrl = 1'b0;
        for (int d = 0; d < NUM_DEC; d++) begin
            if (int'(idx) == int'(DEC_W0 + d * DEC_STRIDE_W + CTL_OFS))
                is_ctrl = 1'b1;
        end
    end

    cmreg_merge u_merge (
        .old_word (st_q.words[idx]),
        .wdata    (bus_wdata),
        .mask     (msk_tbl[idx]),
        .is_ctrl  (is_ctrl),
        .new_word (merged)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.kind  = kind_in;
            st_d.words = rst_tbl;
        end else if (bus_we && hit) begin
            st_d.words[idx] = merged;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bus_rdata = (bus_re && hit) ? st_q.words[idx] : 32'h0;
endmodule

// File: rtl/cmreg_checker.sv
module cmreg_checker
    import cmreg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_WORDS = 44
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_we,
    input logic                    bus_re,
    input logic                    bus_size,
    input logic [31:0]             bus_rdata,
    input logic [NUM_WORDS*32-1:0] words
);
    localparam int unsigned CB = (DEC_W0 + CTL_OFS) * 32;

    assert_wide_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_size) |-> (bus_rdata == 32'h0));

    assert_wide_write_inert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_size) |=> $stable(words));

    assert_commit_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> (words[CB + CTL_COMMIT] == 1'b0));

    assert_committed_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> !$fell(words[CB + CTL_COMMITTED]));

    assert_misaligned_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0));

    assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == 32'h0));

    assert_status_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |->
        (words[UNC_ST_W*32 +: 32] == 32'h0 && words[COR_ST_W*32 +: 32] == 32'h0));

    assert_header_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> $stable(words[31:0]));
endmodule

bind cmreg_file cmreg_checker #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_size  (bus_size),
    .bus_rdata (bus_rdata),
    .words     (st_q.words)
);

// File: tb/test_cmreg_file.sv
`timescale 1ns/1ps
module test_cmreg_file;
    localparam int ADDR_W = 12;
    localparam int NW     = 44;
    localparam int CTLW   = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        comp_type = 3'd0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic              bus_size = 1'b0;
    logic [31:0]       bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model [NW];
    int cur_type = 0;

    always #2 clk = ~clk;

    cmreg_file i_cmreg_file (
        .clk(clk), .rst_n(rst_n), .comp_type(comp_type), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_size(bus_size), .bus_rdata(bus_rdata)
    );

    function automatic int exp_caps(int t);
        if (t == 2 || t == 3 || t == 4) return 3;
        if (t == 5) return 5;
        return 2;
    endfunction

    function automatic logic [31:0] exp_reset(int t, int w);
        int c = exp_caps(t);
        logic [31:0] ent [5] = '{32'h0402_0002, 32'h0602_0004, 32'h0801_0005,
                                 32'h1001_0006, 32'h1401_0008};
        if (w == 0) return {8'(c), 24'h010101};
        if (w >= 1 && w <= 5) return (w - 1 < c) ? ent[w-1] : 32'h0;
        if (w == 17 || w == 18) return 32'h1CFFF;
        if (w == 20) return 32'h7F;
        if (w == 32 && c >= 3) return 32'h310;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_mask(int t, int w);
        bit ep = (t == 1 || t == 3 || t == 4);
        if (w == 17 || w == 18) return 32'h1CFFF;
        if (w == 20) return 32'h7F;
        if (exp_caps(t) < 3) return 32'h0;
        case (w)
            33: return 32'h3;
            36, 38: return 32'hF000_0000;
            37, 39, 42: return 32'hFFFF_FFFF;
            40: return 32'h13FF;
            41: return ep ? 32'hF000_0000 : 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(int w);
        if (w == 0) return "R7";
        if (w >= 1 && w <= 5) return "R8";
        if (w >= 16 && w <= 21) return "R9";
        if (w == 32) return "R10";
        if (w == 33 || w == 40) return "R4";
        if (w == 41) return "R6";
        if (w >= 36) return "R5";
        return "R2";
    endfunction

    function automatic bit serviced(logic [ADDR_W-1:0] a, bit sz);
        return !sz && a[1:0] == 2'b00 && (int'(a) / 4) < NW;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (type %0d)", req, act, exp, cur_type);
        end
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, bit sz, string req);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_re = 1'b1; bus_we = 1'b0;
        #1;
        e = serviced(a, sz) ? model[int'(a) / 4] : 32'h0;
        check(req, bus_rdata, e);
        bus_re = 1'b0;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d, bit sz);
        int w;
        logic [31:0] n, m;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1; bus_re = 1'b0;
        @(posedge clk);
        #1 bus_we = 1'b0;
        if (serviced(a, sz)) begin
            w = int'(a) / 4;
            m = exp_mask(cur_type, w);
            n = (d & m) | (model[w] & ~m);
            if (w == CTLW && n[9]) begin
                n[9] = 1'b0; n[11] = 1'b0; n[10] = 1'b1;
            end
            model[w] = n;
        end
    endtask

    task automatic do_reset(int t);
        @(negedge clk);
        rst_n = 1'b0; comp_type = 3'(t);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_type = t;
        for (int w = 0; w < NW; w++) model[w] = exp_reset(t, w);
    endtask

    task automatic check_all();
        for (int w = 0; w < NW; w++) rd(12'(w * 4), 1'b0, req_of(w));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < 8; t++) begin
            do_reset(t);
            check_all();                                   // R7 R8 R9 R10 reset values
            for (int w = 0; w < NW; w++) wr(12'(w * 4), 32'hFFFF_FFFF, 1'b0);
            check_all();                                   // R2 masks, R3 commit via all-ones
            for (int w = 0; w < NW; w++) wr(12'(w * 4), 32'h0, 1'b0);
            check_all();                                   // R3 committed sticky
            for (int i = 0; i < 150; i++) begin
                int op = int'($urandom_range(0, 3));
                logic [ADDR_W-1:0] a;
                bit sz = ($urandom_range(0, 7) == 0);
                a = 12'($urandom_range(0, NW + 3) * 4);
                if ($urandom_range(0, 7) == 0) a = a + 12'($urandom_range(1, 3));
                if ($urandom_range(0, 3) == 0) a = 12'(CTLW * 4);
                if (op < 2) begin
                    wr(a, $urandom(), sz);
                    rd({a[ADDR_W-1:2], 2'b00}, 1'b0, sz ? "R1" : "R2");
                end else begin
                    rd(a, sz, (sz || a[1:0] != 0) ? "R11" : "R2");
                end
            end
        end

        // R3 directed: commit with low fields
        do_reset(3);
        wr(12'hA0, 32'h0000_0BFF, 1'b0);
        rd(12'hA0, 1'b0, "R3");
        check("R3", model[CTLW], 32'h0000_05FF);
        wr(12'hA0, 32'h0000_0C12, 1'b0);
        rd(12'hA0, 1'b0, "R3");
        check("R3", model[CTLW], 32'h0000_0412);

        // R6 directed: target-low mask per type
        for (int t = 0; t < 6; t++) begin
            do_reset(t);
            wr(12'hA4, 32'hFFFF_FFFF, 1'b0);
            rd(12'hA4, 1'b0, "R6");
        end

        // R1 directed: wide write to a writable word
        do_reset(5);
        wr(12'h94, 32'hDEAD_BEEF, 1'b1);
        rd(12'h94, 1'b0, "R1");
        rd(12'h94, 1'b1, "R1");

        // R12: type latched during reset, write during reset ignored
        @(negedge clk);
        rst_n = 1'b0; comp_type = 3'd1;
        bus_addr = 12'h84; bus_wdata = 32'h3; bus_we = 1'b1; bus_size = 1'b0;
        repeat (2) @(negedge clk);
        comp_type = 3'd5;
        repeat (2) @(negedge clk);
        bus_we = 1'b0; rst_n = 1'b1;
        cur_type = 5;
        for (int w = 0; w < NW; w++) model[w] = exp_reset(5, w);
        comp_type = 3'd1;
        rd(12'h00, 1'b0, "R12");
        check("R12", model[0], 32'h0501_0101);
        rd(12'h84, 1'b0, "R12");
        rd(12'hA4, 1'b0, "R12");
        wr(12'hA4, 32'h1234_5678, 1'b0);
        rd(12'hA4, 1'b0, "R12");
        do_reset(5);
        check_all();

        // R11: out-of-range and misaligned
        rd(12'hB0, 1'b0, "R11");
        rd(12'hFFC, 1'b0, "R11");
        wr(12'h46, 32'h0, 1'b0);
        rd(12'h44, 1'b0, "R11");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule